// File: doc/BRIEF.md
# Per-Locality Interrupt Enable and Status Unit

This block holds an interrupt enable register and an interrupt status register for each of several localities (five by default). The command engine and the locality arbiter report events as one-cycle pulses. Each pulse carries a locality tag and a four-bit source vector. An event is recorded in the tagged locality's status register, and it raises the shared interrupt request, only when that locality has enabled both interrupts as a whole and the individual source. An event that fails this test leaves no trace.

The block also decodes reads and writes for four register kinds: enable, status, a fixed capability word and a hard-wired vector number. The current active locality comes in as an input. Only that locality may change its own enable or status register. Status bits are cleared by writing ones to them. Each enable register carries a two-bit polarity field, and the polarity of the active locality decides whether the physical interrupt pin is active low or active high.

Top module: `irq_unit`

## Requirements
- R1: After reset, every enable register reads 0x00000008 (the low-level polarity code 01 in bits 4:3), every status register reads 0, `irq_active` is 0 and `irq_pin` is 1.
- R2: A write to an enable register keeps only bit 31 (global enable), bits 4:3 (polarity), bit 7 (command ready), bit 2 (locality changed), bit 1 (status valid) and bit 0 (data available). The stored value is the written word ANDed with 0x8000009F.
- R3: Writes to an enable or status register are ignored unless `reg_loc` equals `act_loc` and `act_loc` is a valid locality (below the locality count).
- R4: An event sets a status bit only for the sources whose enable bit is set in the tagged locality, and only while that locality's bit 31 is set. `evt_src` bit 0 maps to status bit 0, bit 1 to bit 1, bit 2 to bit 2, and bit 3 to bit 7.
- R5: `irq_active` goes to 1 on the clock edge where an event sets at least one status bit. An event that is dropped does not change `irq_active`.
- R6: Writing ones to a status register clears those bits among 0, 1, 2 and 7. Ones in any other bit position have no effect.
- R7: `irq_active` goes back to 0 only when a status write clears at least one set bit and leaves the written locality's status at zero. In every other case it holds its value.
- R8: The capability register (`reg_sel` = 2) reads 0x00000097. Writes to it have no effect.
- R9: The vector register (`reg_sel` = 3) reads the `IRQ_NUM` parameter (0 to 15) in bits 3:0. Writes to it have no effect.
- R10: `irq_pin` equals `irq_active` delayed by one cycle. It is inverted when the polarity field of the active locality is 01. When no locality is active, the polarity is taken as 01. Any other polarity code drives the pin active high.
- R11: An event whose locality tag is not below the locality count changes no register and does not raise `irq_active`.
- R12: `rd_valid` pulses one cycle after `reg_rd`, with `rd_data` holding the selected register as it was before that edge. `reg_sel` encodes 0 = enable and 1 = status. A read of an enable or status register with an invalid `reg_loc` returns 0xFFFFFFFF.
- R13: When a status clear and an event for the same locality arrive in the same cycle, the event's bits are applied after the clear, and `irq_active` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_loc | input | LOC_W | Currently active locality; any value not below NUM_LOC means none |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register kind: 0 enable, 1 status, 2 capability, 3 vector |
| reg_loc | input | LOC_W | Locality addressed by the access |
| reg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after reg_rd |
| evt_valid | input | 1 | Event pulse |
| evt_loc | input | LOC_W | Locality tag of the event |
| evt_src | input | 4 | Event sources: data available, status valid, locality changed, command ready |
| irq_active | output | 1 | Logical interrupt request |
| irq_pin | output | 1 | Physical interrupt pin, polarity per active locality |

## Verification
The bench targets the masking corners. It sends events that name only disabled sources, or that arrive while the global bit is off. A design that ORed the whole event vector into status, or ignored bit 31, would show status bits and a raised request at those points. It writes from localities that do not own the interface, and writes ones to unsupported status positions; a missing qualifier or a missing mask would alter registers that read back unchanged. It also clears status one bit at a time, to catch a design that drops the request early, and it drives a clear and an event into the same locality in the same cycle. Finally it steps the active locality through different polarity codes and through the no-owner value, which exposes a pin that is not inverted correctly or is taken from the wrong locality.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;

  localparam int SRC_N = 4;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CAP    = 2'd2,
    SEL_VECTOR = 2'd3
  } reg_sel_e;

  // compact storage of one enable register
  typedef struct packed {
    logic             gen;
    logic [1:0]       pol;
    logic [SRC_N-1:0] src;
  } inte_t;

  localparam logic [1:0] POL_LOW_LEVEL = 2'b01;
  localparam inte_t INTE_RESET = '{gen: 1'b0, pol: POL_LOW_LEVEL, src: '0};

  // capability: low-level support flag plus the four source positions
  localparam logic [31:0] CAP_WORD = 32'h0000_0010 | 32'h0000_0087;

  function automatic logic [31:0] src_to_word(input logic [SRC_N-1:0] s);
    logic [31:0] w;
    w      = '0;
    w[2:0] = s[2:0];
    w[7]   = s[3];
    return w;
  endfunction

  function automatic logic [31:0] inte_to_word(input inte_t e);
    logic [31:0] w;
    w      = src_to_word(e.src);
    w[31]  = e.gen;
    w[4:3] = e.pol;
    return w;
  endfunction

endpackage

// File: rtl/irq_loc_regs.sv
module irq_loc_regs
  import irq_unit_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_ok,
  input  reg_sel_e                        wr_sel,
  input  logic [LOC_W-1:0]                wr_loc,
  input  logic [31:0]                     wr_data,
  input  logic                            evt_valid,
  input  logic [LOC_W-1:0]                evt_loc,
  input  logic [SRC_N-1:0]                evt_src,
  output inte_t [NUM_LOC-1:0]             en_q,
  output logic  [NUM_LOC-1:0][SRC_N-1:0]  st_q,
  output logic                            evt_hit,
  output logic                            clr_done
);

  logic [SRC_N-1:0] wr_src;
  inte_t            wr_inte;
  logic             unused_wr_bits;

  assign wr_src         = {wr_data[7], wr_data[2:0]};
  assign wr_inte        = '{gen: wr_data[31], pol: wr_data[4:3], src: wr_src};
  assign unused_wr_bits = ^{wr_data[30:8], wr_data[6:5]};

  inte_t            en_r [NUM_LOC];
  logic [SRC_N-1:0] st_r [NUM_LOC];
  logic [NUM_LOC-1:0] hit_v;
  logic [NUM_LOC-1:0] drop_v;

  for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
    logic             mine;
    logic [SRC_N-1:0] acc;
    logic [SRC_N-1:0] clr;
    logic [SRC_N-1:0] kept;

    assign mine = wr_ok && (wr_loc == LOC_W'(g));
    assign acc  = (evt_valid && (evt_loc == LOC_W'(g)) && en_r[g].gen)
                  ? (en_r[g].src & evt_src) : '0;
    assign clr  = (mine && (wr_sel == SEL_STATUS)) ? wr_src : '0;
    assign kept = st_r[g] & ~clr;

    assign hit_v[g]  = |acc;
    assign drop_v[g] = (|clr) && (|st_r[g]) && (kept == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r[g] <= INTE_RESET;
        st_r[g] <= '0;
      end else begin
        if (mine && (wr_sel == SEL_ENABLE)) begin
          en_r[g] <= wr_inte;
        end
        st_r[g] <= kept | acc;
      end
    end

    assign en_q[g] = en_r[g];
    assign st_q[g] = st_r[g];
  end

  assign evt_hit  = |hit_v;
  assign clr_done = |drop_v;

endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl
  import irq_unit_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LOC_W   = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                evt_hit,
  input  logic                clr_done,
  input  logic [LOC_W-1:0]    act_loc,
  input  inte_t [NUM_LOC-1:0] en_q,
  output logic                irq_active,
  output logic                irq_pin
);

  logic [1:0] act_pol;
  logic       low_level;

  always_comb begin
    act_pol = POL_LOW_LEVEL;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (act_loc == LOC_W'(i)) act_pol = en_q[i].pol;
    end
  end

  assign low_level = (act_pol == POL_LOW_LEVEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_active <= 1'b0;
      irq_pin    <= 1'b1;
    end else begin
      if (evt_hit)       irq_active <= 1'b1;
      else if (clr_done) irq_active <= 1'b0;
      irq_pin <= irq_active ^ low_level;
    end
  end

endmodule

// File: rtl/irq_read_port.sv
module irq_read_port
  import irq_unit_pkg::*;
#(
  parameter int          NUM_LOC = 5,
  parameter int          LOC_W   = 3,
  parameter logic [3:0]  IRQ_NUM = 4'd10
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           reg_rd,
  input  reg_sel_e                       reg_sel,
  input  logic [LOC_W-1:0]               reg_loc,
  input  inte_t [NUM_LOC-1:0]            en_q,
  input  logic [NUM_LOC-1:0][SRC_N-1:0]  st_q,
  output logic [31:0]                    rd_data,
  output logic                           rd_valid
);

  logic [31:0] en_word;
  logic [31:0] st_word;
  logic [31:0] mux;

  always_comb begin
    en_word = '1;
    st_word = '1;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (reg_loc == LOC_W'(i)) begin
        en_word = inte_to_word(en_q[i]);
        st_word = src_to_word(st_q[i]);
      end
    end
    unique case (reg_sel)
      SEL_ENABLE: mux = en_word;
      SEL_STATUS: mux = st_word;
      SEL_CAP:    mux = CAP_WORD;
      SEL_VECTOR: mux = {28'd0, IRQ_NUM};
      default:    mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= mux;
    end
  end

endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] IRQ_NUM = 4'd10,
  localparam int        LOC_W   = $clog2(NUM_LOC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LOC_W-1:0] act_loc,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_sel,
  input  logic [LOC_W-1:0] reg_loc,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  input  logic             evt_valid,
  input  logic [LOC_W-1:0] evt_loc,
  input  logic [3:0]       evt_src,
  output logic             irq_active,
  output logic             irq_pin
);

  reg_sel_e                      sel;
  logic                          wr_ok;
  inte_t [NUM_LOC-1:0]           en_q;
  logic  [NUM_LOC-1:0][SRC_N-1:0] st_q;
  logic                          evt_hit;
  logic                          clr_done;

  assign sel   = reg_sel_e'(reg_sel);
  // only the owning locality may change its enable or status register
  assign wr_ok = reg_wr && (reg_loc == act_loc) && (int'(act_loc) < NUM_LOC);

  irq_loc_regs #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_ok    (wr_ok),
    .wr_sel   (sel),
    .wr_loc   (reg_loc),
    .wr_data  (reg_wdata),
    .evt_valid(evt_valid),
    .evt_loc  (evt_loc),
    .evt_src  (evt_src),
    .en_q     (en_q),
    .st_q     (st_q),
    .evt_hit  (evt_hit),
    .clr_done (clr_done)
  );

  irq_line_ctl #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .evt_hit   (evt_hit),
    .clr_done  (clr_done),
    .act_loc   (act_loc),
    .en_q      (en_q),
    .irq_active(irq_active),
    .irq_pin   (irq_pin)
  );

  irq_read_port #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .IRQ_NUM(IRQ_NUM)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .reg_rd  (reg_rd),
    .reg_sel (sel),
    .reg_loc (reg_loc),
    .en_q    (en_q),
    .st_q    (st_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

endmodule

// File: rtl/irq_unit_chk.sv
module irq_unit_chk #(
  parameter int         NUM_LOC = 5,
  parameter logic [3:0] IRQ_NUM = 4'd10,
  parameter int         LOC_W   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_sel,
  input logic [31:0]      rd_data,
  input logic             rd_valid,
  input logic             evt_valid,
  input logic [LOC_W-1:0] evt_loc,
  input logic             irq_active
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_active && !rd_valid));

  assert_cap_word_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(reg_sel) == 2'd2) |-> (rd_data == 32'h0000_0097));

  assert_vector_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(reg_sel) == 2'd3) |-> (rd_data == {28'd0, IRQ_NUM}));

  assert_request_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_active && !reg_wr) |=> irq_active);

  assert_bad_tag_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && int'(evt_loc) >= NUM_LOC && !irq_active) |=> !irq_active);

  assert_no_event_no_raise_R5: assert property (@(posedge clk) disable iff (rst)
    (!evt_valid && !irq_active) |=> !irq_active);

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> rd_valid);

  assert_no_spurious_read_R12: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !rd_valid);

endmodule

bind irq_unit irq_unit_chk #(.NUM_LOC(NUM_LOC), .IRQ_NUM(IRQ_NUM), .LOC_W(LOC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_sel   (reg_sel),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .evt_valid (evt_valid),
  .evt_loc   (evt_loc),
  .irq_active(irq_active)
);

// File: tb/tb_irq_unit.sv
module tb_irq_unit;

  localparam int         CLK_PERIOD = 10;
  localparam int         NUM_LOC    = 5;
  localparam int         LOC_W      = $clog2(NUM_LOC + 1);
  localparam logic [3:0] VEC        = 4'd11;
  localparam logic [LOC_W-1:0] NO_LOC = LOC_W'(7);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [LOC_W-1:0] act_loc = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [1:0]       reg_sel = '0;
  logic [LOC_W-1:0] reg_loc = '0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      rd_data;
  logic             rd_valid;
  logic             evt_valid = 1'b0;
  logic [LOC_W-1:0] evt_loc = '0;
  logic [3:0]       evt_src = '0;
  logic             irq_active;
  logic             irq_pin;

  int    n_vec  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_unit #(.NUM_LOC(NUM_LOC), .IRQ_NUM(VEC)) dut (
    .clk(clk), .rst(rst), .act_loc(act_loc), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_loc(reg_loc), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .evt_valid(evt_valid),
    .evt_loc(evt_loc), .evt_src(evt_src), .irq_active(irq_active), .irq_pin(irq_pin)
  );

  // monitor: pops the expected read result when the design presents one
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R12: unexpected read data %h, expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          n_bad++;
          $display("FAIL %s: read got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [LOC_W-1:0] l, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_loc = l; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [LOC_W-1:0] l,
                    input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_sel = s; reg_loc = l;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ev(input logic [LOC_W-1:0] l, input logic [3:0] s);
    evt_valid = 1'b1; evt_loc = l; evt_src = s;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string t, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %b expected %b", t, what, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk(irq_active, 1'b0, "R1", "irq_active");
    chk(irq_pin, 1'b1, "R1", "irq_pin");
    rd(2'd0, 3'd0, 32'h0000_0008, "R1");
    rd(2'd1, 3'd4, 32'h0000_0000, "R1");

    // R3 no owner: write ignored
    act_loc = NO_LOC;
    wr(2'd0, 3'd0, 32'hFFFF_FFFF);
    rd(2'd0, 3'd0, 32'h0000_0008, "R3");

    // R2 masking of enable write
    act_loc = 3'd0;
    wr(2'd0, 3'd0, 32'hFFFF_FFFF);
    rd(2'd0, 3'd0, 32'h8000_009F, "R2");
    // R3 other locality's enable not writable
    wr(2'd0, 3'd1, 32'hFFFF_FFFF);
    rd(2'd0, 3'd1, 32'h0000_0008, "R3");

    // low-level polarity, all sources
    wr(2'd0, 3'd0, 32'h8000_008F);
    ev(3'd0, 4'b1111);
    chk(irq_active, 1'b1, "R5", "irq_active after event");
    rd(2'd1, 3'd0, 32'h0000_0087, "R4");
    chk(irq_pin, 1'b0, "R10", "pin active-low");

    // R7 partial clear keeps request
    wr(2'd1, 3'd0, 32'h0000_0001);
    rd(2'd1, 3'd0, 32'h0000_0086, "R7");
    chk(irq_active, 1'b1, "R7", "irq_active after partial clear");
    // R6 unsupported positions
    wr(2'd1, 3'd0, 32'h7FFF_FF78);
    rd(2'd1, 3'd0, 32'h0000_0086, "R6");
    // R7 full clear drops request
    wr(2'd1, 3'd0, 32'h0000_0086);
    chk(irq_active, 1'b0, "R7", "irq_active after full clear");
    rd(2'd1, 3'd0, 32'h0000_0000, "R7");
    chk(irq_pin, 1'b1, "R10", "pin idle high");

    // R4 global enable off: dropped
    wr(2'd0, 3'd0, 32'h0000_0009);
    ev(3'd0, 4'b0001);
    chk(irq_active, 1'b0, "R5", "dropped event raised request");
    rd(2'd1, 3'd0, 32'h0000_0000, "R4");
    // R4 disabled sources dropped
    wr(2'd0, 3'd0, 32'h8000_0009);
    ev(3'd0, 4'b1110);
    chk(irq_active, 1'b0, "R5", "disabled source raised request");
    rd(2'd1, 3'd0, 32'h0000_0000, "R4");
    // R11 invalid locality tag
    ev(3'd6, 4'b1111);
    chk(irq_active, 1'b0, "R11", "bad tag raised request");
    rd(2'd1, 3'd0, 32'h0000_0000, "R11");

    // R10 active-high polarity, then follow the active locality
    wr(2'd0, 3'd0, 32'h8000_0011);
    ev(3'd0, 4'b0001);
    chk(irq_active, 1'b1, "R5", "irq_active");
    idle(1);
    chk(irq_pin, 1'b1, "R10", "pin active-high");
    act_loc = NO_LOC;
    idle(2);
    chk(irq_pin, 1'b0, "R10", "pin with no owner");
    act_loc = 3'd3;
    wr(2'd0, 3'd3, 32'h0000_0010);
    idle(1);
    chk(irq_pin, 1'b1, "R10", "pin follows owner polarity");

    // R3 status clear from non-owner ignored
    wr(2'd1, 3'd0, 32'h0000_0001);
    rd(2'd1, 3'd0, 32'h0000_0001, "R3");
    chk(irq_active, 1'b1, "R3", "irq_active after foreign clear");

    // R13 clear and event together
    act_loc = 3'd0;
    reg_wr = 1'b1; reg_sel = 2'd1; reg_loc = 3'd0; reg_wdata = 32'h1;
    evt_valid = 1'b1; evt_loc = 3'd0; evt_src = 4'b0001;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0;
    chk(irq_active, 1'b1, "R13", "irq_active after clear+event");
    rd(2'd1, 3'd0, 32'h0000_0001, "R13");
    wr(2'd1, 3'd0, 32'h0000_0001);
    chk(irq_active, 1'b0, "R7", "irq_active after last clear");

    // R8 / R9 fixed registers
    wr(2'd2, 3'd0, 32'h0);
    rd(2'd2, 3'd0, 32'h0000_0097, "R8");
    wr(2'd3, 3'd0, 32'h0000_0003);
    rd(2'd3, 3'd0, {28'd0, VEC}, "R9");
    // R12 invalid read locality
    rd(2'd0, 3'd6, 32'hFFFF_FFFF, "R12");
    rd(2'd1, 3'd5, 32'hFFFF_FFFF, "R12");
    idle(1);
    chk(rd_valid, 1'b0, "R12", "rd_valid idle");

    idle(2);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R12: %0d reads got no result, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule